// File: doc/BRIEF.md
# Memory-Mapped GPIO Block with Per-Pin Interrupts

This block gives software control of a small group of general-purpose pins over a 32-bit register bus. Each pin can act as an input or an output. Software reads the synchronized pin levels from an input register. Output levels change only through two write-only registers: one sets bits and the other clears them. Because of this, no read-modify-write is needed to change a single pin.

Each pin also has interrupt logic. The sense can be level or edge, with a polarity that picks high/rising or low/falling. A pin passes its interrupt through two gates, an enable bit and a mask bit. All gated pins are ORed into one registered request line. Software can emulate detection of both edges: on each interrupt it flips the polarity bit to the opposite of the current pin level.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `pin_out`, `pin_oe` and `irq` are 0. Every interrupt register reads 0. The direction register holds the value that makes every pin an input: 0 when `DIR_INVERTED`=0, all ones when it is 1.
- R2: A write of 1 to a bit of the set register (byte offset 0x0C) drives that `pin_out` bit high. A write of 1 to a bit of the clear register (offset 0x10) drives it low. Bits written as 0 leave the output unchanged. The new value appears on `pin_out` one cycle after the write.
- R3: The direction register is at offset 0x00 and reads back as written. With `DIR_INVERTED`=0, `pin_oe[i]` equals direction bit i. With `DIR_INVERTED`=1, `pin_oe[i]` is its inverse.
- R4: The input register (offset 0x04) returns `pin_in` after a two-flop synchronizer. A level that is held on the pins is returned by any read issued two or more cycles after it was applied.
- R5: With interrupt type bit 0 (edge sense, type register 0x18), a change of the synchronized pin toward its polarity bit sets the pending bit. A polarity bit of 1 (register 0x1C) selects rising; 0 selects falling. The pending bit stays set until a read of the pending register (0x20), and that read clears it. An event in the same cycle as the read is kept.
- R6: With type bit 1 (level sense), the pending bit is 1 exactly while the synchronized pin equals its polarity bit. Reads of the pending register do not change it.
- R7: A write to the type or polarity register while the pins are steady creates no edge event.
- R8: `irq` is the registered OR over pins of pending AND enable (0x14) AND mask (0x24), where a mask bit of 1 means unmasked. `irq` rises one cycle after the gated pending term becomes true. It stays 0 whenever no pin has both its enable and mask bits set.
- R9: Read data appears on `bus_rdata` one cycle after a read is presented and holds until the next read. The set and clear registers, unmapped offsets, and all bits at or above `PIN_COUNT` read as 0. Writes to bits at or above `PIN_COUNT` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | PIN_COUNT | Asynchronous pin levels |
| pin_out | output | PIN_COUNT | Output levels |
| pin_oe | output | PIN_COUNT | Output enables, 1 = drive |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong latched edge state shows on `irq` two cycles after the synchronized pin change, and in the next pending read. A clear-on-read fault is seen when a second read returns the bit again. A stale previous-value register shows as a false pending bit right after a polarity write with steady pins. Mis-decoded enable or mask state shows on `irq` one cycle after the write that should have gated it. A faulty output or direction latch shows on `pin_out` or `pin_oe` in the cycle after the write.

// File: rtl/gpio_irq_pkg.sv
// Package: shared register selector type and address decode for the GPIO block.
// Assumes word-aligned byte offsets on an 8-bit address.
package gpio_irq_pkg;

    localparam int BUS_AW = 8;
    localparam int BUS_DW = 32;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_DIR,
        SEL_IN,
        SEL_SET,
        SEL_CLR,
        SEL_IEN,
        SEL_ITYPE,
        SEL_IPOL,
        SEL_IPEND,
        SEL_IMASK
    } reg_sel_e;

    // Map a byte offset to a register selector.
    function automatic reg_sel_e decode_off(input logic [BUS_AW-1:0] off);
        reg_sel_e s;
        case (off)
            8'h00:   s = SEL_DIR;
            8'h04:   s = SEL_IN;
            8'h0C:   s = SEL_SET;
            8'h10:   s = SEL_CLR;
            8'h14:   s = SEL_IEN;
            8'h18:   s = SEL_ITYPE;
            8'h1C:   s = SEL_IPOL;
            8'h20:   s = SEL_IPEND;
            8'h24:   s = SEL_IMASK;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
// Module: multi-stage synchronizer for the asynchronous pin inputs.
// Assumes each bit is an independent level; no bus coherency is promised.
module gpio_sync #(
    parameter int N      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_async,
    output logic [N-1:0] d_sync
);

    logic [N-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First capture flop.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d_async;
                end
            end else begin : g_next
                // Later resolution flops.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign d_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regfile.sv
// Module: writable control registers of the GPIO block.
// Assumes one write per cycle; only the low N data bits are stored.
module gpio_regfile
    import gpio_irq_pkg::*;
#(
    parameter int N            = 8,
    parameter bit DIR_INVERTED = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          wr_sel,
    input  logic [BUS_DW-1:0] wdata,
    output logic [N-1:0]      dir_q,
    output logic [N-1:0]      out_q,
    output logic [N-1:0]      ien_q,
    output logic [N-1:0]      itype_q,
    output logic [N-1:0]      ipol_q,
    output logic [N-1:0]      imask_q
);

    localparam logic [N-1:0] DIR_RESET = DIR_INVERTED ? {N{1'b1}} : {N{1'b0}};

    logic [N-1:0] wbits;
    assign wbits = wdata[N-1:0];

    // Direction register; reset value means "input" in either variant.
    always_ff @(posedge clk) begin
        if (!rst_n)                          dir_q <= DIR_RESET;
        else if (wr_en && wr_sel == SEL_DIR) dir_q <= wbits;
    end

    // Output latch updated only by the set and clear strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)                          out_q <= '0;
        else if (wr_en && wr_sel == SEL_SET) out_q <= out_q | wbits;
        else if (wr_en && wr_sel == SEL_CLR) out_q <= out_q & ~wbits;
    end

    // Interrupt enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ien_q <= '0;
        else if (wr_en && wr_sel == SEL_IEN) ien_q <= wbits;
    end

    // Interrupt sense type register (1 = level).
    always_ff @(posedge clk) begin
        if (!rst_n)                            itype_q <= '0;
        else if (wr_en && wr_sel == SEL_ITYPE) itype_q <= wbits;
    end

    // Interrupt polarity register (1 = high / rising).
    always_ff @(posedge clk) begin
        if (!rst_n)                           ipol_q <= '0;
        else if (wr_en && wr_sel == SEL_IPOL) ipol_q <= wbits;
    end

    // Interrupt mask register (1 = unmasked).
    always_ff @(posedge clk) begin
        if (!rst_n)                            imask_q <= '0;
        else if (wr_en && wr_sel == SEL_IMASK) imask_q <= wbits;
    end

endmodule

// File: rtl/gpio_irq_detect.sv
// Module: per-pin edge/level sensing and pending state.
// Assumes synchronized inputs; an edge event wins over a same-cycle clear.
module gpio_irq_detect #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_sync,
    input  logic [N-1:0] itype,
    input  logic [N-1:0] ipol,
    input  logic         pend_rd,
    output logic [N-1:0] pending
);

    logic [N-1:0] prev_q;

    // Previous synchronized value, tracked independently of configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_sync;
    end

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_pin
            logic lvl_hit;
            logic edge_evt;
            logic edge_q;

            assign lvl_hit  = (pin_sync[i] == ipol[i]);
            assign edge_evt = !itype[i] && (pin_sync[i] != prev_q[i]) && lvl_hit;

            // Latched edge flag: set by event, cleared by read, idle in level mode.
            always_ff @(posedge clk) begin
                if (!rst_n)        edge_q <= 1'b0;
                else if (itype[i]) edge_q <= 1'b0;
                else if (edge_evt) edge_q <= 1'b1;
                else if (pend_rd)  edge_q <= 1'b0;
            end

            assign pending[i] = itype[i] ? lvl_hit : edge_q;
        end
    endgenerate

endmodule

// File: rtl/gpio_irq_ctrl.sv
// Module: top of the GPIO block with interrupt aggregation and register reads.
// Assumes PIN_COUNT is between 1 and 31 and one bus access per strobe cycle.
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int PIN_COUNT    = 8,
    parameter bit DIR_INVERTED = 1'b0,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [BUS_AW-1:0]    bus_addr,
    input  logic [BUS_DW-1:0]    bus_wdata,
    output logic [BUS_DW-1:0]    bus_rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic                 irq
);

    reg_sel_e             sel;
    logic                 wr_en;
    logic                 rd_en;
    logic [PIN_COUNT-1:0] pin_sync;
    logic [PIN_COUNT-1:0] dir_q;
    logic [PIN_COUNT-1:0] out_q;
    logic [PIN_COUNT-1:0] ien_q;
    logic [PIN_COUNT-1:0] itype_q;
    logic [PIN_COUNT-1:0] ipol_q;
    logic [PIN_COUNT-1:0] imask_q;
    logic [PIN_COUNT-1:0] pending;
    logic [PIN_COUNT-1:0] rd_bits;
    logic                 irq_q;
    logic [BUS_DW-1:0]    rdata_q;

    assign sel   = decode_off(bus_addr);
    assign wr_en = bus_sel && bus_wr;
    assign rd_en = bus_sel && !bus_wr;

    gpio_sync #(.N(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .d_sync  (pin_sync)
    );

    gpio_regfile #(.N(PIN_COUNT), .DIR_INVERTED(DIR_INVERTED)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (sel),
        .wdata   (bus_wdata),
        .dir_q   (dir_q),
        .out_q   (out_q),
        .ien_q   (ien_q),
        .itype_q (itype_q),
        .ipol_q  (ipol_q),
        .imask_q (imask_q)
    );

    gpio_irq_detect #(.N(PIN_COUNT)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_sync (pin_sync),
        .itype    (itype_q),
        .ipol     (ipol_q),
        .pend_rd  (rd_en && sel == SEL_IPEND),
        .pending  (pending)
    );

    // Read multiplexer; write-only and unmapped offsets return zero.
    always_comb begin
        case (sel)
            SEL_DIR:   rd_bits = dir_q;
            SEL_IN:    rd_bits = pin_sync;
            SEL_IEN:   rd_bits = ien_q;
            SEL_ITYPE: rd_bits = itype_q;
            SEL_IPOL:  rd_bits = ipol_q;
            SEL_IPEND: rd_bits = pending;
            SEL_IMASK: rd_bits = imask_q;
            default:   rd_bits = '0;
        endcase
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= BUS_DW'(rd_bits);
    end

    // Registered combined interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(pending & ien_q & imask_q);
    end

    assign bus_rdata = rdata_q;
    assign irq       = irq_q;
    assign pin_out   = out_q;
    assign pin_oe    = DIR_INVERTED ? ~dir_q : dir_q;

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
// Module: assertion checker bound to the GPIO top.
// Assumes the same byte offsets as the package decode.
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int N = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [BUS_DW-1:0] bus_rdata,
    input logic [N-1:0]      pin_out,
    input logic [N-1:0]      pin_oe,
    input logic              irq,
    input logic [N-1:0]      ien_q,
    input logic [N-1:0]      imask_q
);

    logic wr_out, wr_dir, rd_wo;
    assign wr_out = bus_sel && bus_wr && (bus_addr == 8'h0C || bus_addr == 8'h10);
    assign wr_dir = bus_sel && bus_wr && (bus_addr == 8'h00);
    assign rd_wo  = bus_sel && !bus_wr && (bus_addr == 8'h0C || bus_addr == 8'h10);

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!irq && pin_out == '0 && pin_oe == '0));

    p_out_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_out) |-> $stable(pin_out));

    p_oe_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_dir) |-> $stable(pin_oe));

    p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(|(ien_q & imask_q)));

    p_wo_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_wo) |-> bus_rdata == '0);

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.N(PIN_COUNT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .ien_q     (ien_q),
    .imask_q   (imask_q)
);

// File: tb/gpio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb;

    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out;
    logic [N-1:0]  pin_oe;
    logic          irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    gpio_irq_ctrl #(.PIN_COUNT(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // Level-sense vectors: {polarity, pins, expected pending}.
    localparam logic [23:0] LVL_VEC [6] = '{
        {8'hFF, 8'hA5, 8'hA5},
        {8'h00, 8'hA5, 8'h5A},
        {8'hF0, 8'h3C, 8'h33},
        {8'h0F, 8'h3C, 8'hCC},
        {8'hFF, 8'h00, 8'h00},
        {8'h00, 8'h00, 8'hFF}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pins(input logic [N-1:0] v, input int wait_cyc);
        @(negedge clk);
        pin_in = v;
        repeat (wait_cyc) @(negedge clk);
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 pin_out", 32'(pin_out), 0);
        check("R1 pin_oe", 32'(pin_oe), 0);
        check("R1 irq", 32'(irq), 0);
        rd(8'h00, d); check("R1 dir", d, 0);
        rd(8'h20, d); check("R1 pending", d, 0);
        rd(8'h24, d); check("R1 mask", d, 0);

        // R3 and R9: direction readback, upper bits dropped
        wr(8'h00, 32'hFFFF_FF55);
        check("R3 pin_oe", 32'(pin_oe), 32'h55);
        rd(8'h00, d); check("R3 R9 dir readback", d, 32'h55);

        // R2: set and clear
        wr(8'h0C, 32'h0000_000F);
        check("R2 set", 32'(pin_out), 32'h0F);
        wr(8'h10, 32'h0000_0003);
        check("R2 clear", 32'(pin_out), 32'h0C);
        wr(8'h0C, 32'hFFFF_FF00);
        check("R2 R9 upper set bits ignored", 32'(pin_out), 32'h0C);
        wr(8'h10, 32'h0000_0000);
        check("R2 zero clear", 32'(pin_out), 32'h0C);

        // R9: write-only and unmapped reads
        rd(8'h0C, d); check("R9 set reads zero", d, 0);
        rd(8'h30, d); check("R9 unmapped reads zero", d, 0);

        // R4: synchronized input readback
        pins(8'h96, 2);
        rd(8'h04, d); check("R4 input", d, 32'h96);

        // R6 and R8: level-sense vector table
        wr(8'h14, 32'hFF);
        wr(8'h24, 32'hFF);
        wr(8'h18, 32'hFF);
        for (int k = 0; k < 6; k++) begin
            wr(8'h1C, 32'(LVL_VEC[k][23:16]));
            pins(LVL_VEC[k][15:8], 3);
            check($sformatf("R8 level irq row %0d", k), 32'(irq), 32'(|LVL_VEC[k][7:0]));
            rd(8'h20, d);
            check($sformatf("R6 level pending row %0d", k), d, 32'(LVL_VEC[k][7:0]));
        end

        // R7: switch to edge mode and flip polarity with steady pins
        pins(8'h00, 3);
        wr(8'h18, 32'h00);
        rd(8'h20, d);
        wr(8'h1C, 32'hFF);
        repeat (3) @(negedge clk);
        rd(8'h20, d); check("R7 polarity write no event", d, 0);
        wr(8'h18, 32'h00);
        repeat (3) @(negedge clk);
        rd(8'h20, d); check("R7 type write no event", d, 0);

        // R5: rising edge latches, read clears
        pins(8'h01, 4);
        check("R8 edge irq", 32'(irq), 1);
        rd(8'h20, d); check("R5 rising pending", d, 32'h01);
        rd(8'h20, d); check("R5 cleared on read", d, 0);
        @(negedge clk);
        check("R8 irq drops after clear", 32'(irq), 0);
        pins(8'h01, 4);
        rd(8'h20, d); check("R5 steady pin no new event", d, 0);

        // R5: falling edge on pin 1 with polarity 0
        wr(8'h1C, 32'hFD);
        pins(8'h03, 4);
        rd(8'h20, d); check("R5 rise ignored when falling selected", d, 0);
        pins(8'h01, 4);
        rd(8'h20, d); check("R5 falling pending", d, 32'h02);

        // R6 and R8: gating on pin 0 in level mode
        wr(8'h18, 32'h01);
        wr(8'h1C, 32'h01);
        wr(8'h14, 32'h01);
        wr(8'h24, 32'h00);
        repeat (2) @(negedge clk);
        check("R8 masked irq", 32'(irq), 0);
        rd(8'h20, d); check("R6 level pending held", d, 32'h01);
        rd(8'h20, d); check("R6 level pending not cleared by read", d, 32'h01);
        wr(8'h24, 32'h01);
        wr(8'h14, 32'h00);
        repeat (2) @(negedge clk);
        check("R8 disabled irq", 32'(irq), 0);
        wr(8'h14, 32'h01);
        repeat (2) @(negedge clk);
        check("R8 enabled and unmasked irq", 32'(irq), 1);
        pins(8'h00, 3);
        check("R6 R8 level release", 32'(irq), 0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule